// File: doc/BRIEF.md
# Multi-Channel Compare-Match Periodic Timer

This block is a group of independent 16-bit up-counting timer channels behind a byte-wide register port. Each channel counts ticks from its own internal prescaler. When the count equals the channel's compare register on a tick, a match event occurs. The match sets a sticky flag, can send the counter back to zero, drives two output pins through programmable actions, and raises the channel's interrupt when that interrupt is enabled.

Software programs a channel while it is halted. It then starts the channel through one shared run register that holds one bit per channel. A typical use is a periodic system tick: the compare value is C, clear-on-match is selected, and the interrupt fires once every C+1 prescaled ticks. The interrupt handler acknowledges the flag by reading the status byte and then writing 0 to the flag bit.

Top module: `match_timer`

## Requirements
- R1: After reset every channel register and the run register read 0, every pin output is low and every interrupt output is low.
- R2: Channel n occupies byte addresses n*16 to n*16+15, at these offsets: control 0, mode 1, pin-action 2, interrupt enable 4, status 5, counter high byte 6, counter low byte 7, compare high byte 8, compare low byte 9. The run register sits at address NUM_CH*16. Every other offset and address reads 0, and writes to them change nothing.
- R3: Run-register bit n set to 1 makes channel n count and 0 holds it. The register reads back as written, and each bit affects only its own channel.
- R4: Control bits [2:0] pick the prescaler: 0 gives a tick every cycle, 1 divides by 4, 2 by 16 and 3 by 64. Codes 4 to 7 give no ticks. The prescaler phase restarts at 0 whenever the channel is held, so running cycle j (j = 0 in the first cycle after the run bit is set) is the phase.
- R5: Control bits [4:3] pick the prescaled edge for a divide ratio N > 1. Code 0 (rising) ticks when j mod N = N/2-1, code 1 (falling) ticks when j mod N = N-1, and codes 2 and 3 (both) tick on either phase.
- R6: On each tick the counter goes up by 1, and it wraps from 0xFFFF to 0 without setting the flag unless that is also a match.
- R7: A match is a tick on which the counter equals the compare register. A match sets status bit 0. With control bits [7:5] = 1 the counter then returns to 0, which gives a period of compare+1 ticks. With any other code the counter keeps counting.
- R8: The channel counts only while mode bits [3:0] = 0. Any other mode value holds the counter.
- R9: Pin-action byte bits [7:4] drive pin_hi and bits [3:0] drive pin_lo. In each field, bits [1:0] give the action on a match: 1 clear, 2 set, 3 toggle. Bit 2 gives the level loaded into the pin when the field is written with a nonzero action. A field with action 0, or with bit 3 set, leaves the pin unchanged.
- R10: Writing status bit 0 as 0 clears the flag only if the most recent status read saw the flag at 1. Writing 1 leaves the flag unchanged.
- R11: A match in the same cycle as a valid flag clear wins, and the flag stays set.
- R12: A channel's interrupt output is high exactly when its flag is set and its interrupt enable bit 0 is 1.
- R13: A counter byte write takes effect at once, even while the channel runs, and it replaces that cycle's tick increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Byte write strobe |
| bus_rd | input | 1 | Byte read strobe (arms the flag clear on status reads) |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from bus_addr |
| pin_hi | output | NUM_CH | Upper-field compare pin per channel |
| pin_lo | output | NUM_CH | Lower-field compare pin per channel |
| irq | output | NUM_CH | Per-channel compare interrupt |

## Verification
The bench uses the defaults NUM_CH = 3 and ADDR_W = 6. This places the run register at 0x30 and leaves 0x31 to 0x3F as unassigned space whose reads must return 0. Three channels make it possible to run channel 1 alone, check that a halted channel 0 keeps its count, and check that registers written in channel 2 do not appear in channel 0. Because the prescaler phase restarts at start, every divide ratio up to 64 and every edge code produces a tick count that a short run can predict exactly.

// File: rtl/mt_pkg.sv
`timescale 1ns/1ps
package mt_pkg;
  localparam int PRE_W = 6;
  localparam int CNT_W = 16;
  localparam int OFF_W = 4;

  localparam logic [3:0] OFF_CTRL = 4'd0;
  localparam logic [3:0] OFF_MODE = 4'd1;
  localparam logic [3:0] OFF_IOC  = 4'd2;
  localparam logic [3:0] OFF_IEN  = 4'd4;
  localparam logic [3:0] OFF_STAT = 4'd5;
  localparam logic [3:0] OFF_CNTH = 4'd6;
  localparam logic [3:0] OFF_CNTL = 4'd7;
  localparam logic [3:0] OFF_CMPH = 4'd8;
  localparam logic [3:0] OFF_CMPL = 4'd9;

  localparam logic [2:0] CLR_CMPA = 3'd1;

  // Tick decision for one prescaler phase value.
  function automatic logic presc_tick(input logic [2:0] psc, input logic [1:0] edg,
                                      input logic [PRE_W-1:0] phase);
    logic [PRE_W-1:0] mask;
    logic hit_r, hit_f, res;
    mask = '0;
    case (psc)
      3'd1: mask = PRE_W'(3);
      3'd2: mask = PRE_W'(15);
      3'd3: mask = PRE_W'(63);
      default: mask = '0;
    endcase
    hit_r = (phase & mask) == (mask >> 1);
    hit_f = (phase & mask) == mask;
    if (psc == 3'd0)      res = 1'b1;
    else if (psc > 3'd3)  res = 1'b0;
    else if (edg == 2'd0) res = hit_r;
    else if (edg == 2'd1) res = hit_f;
    else                  res = hit_r | hit_f;
    return res;
  endfunction

  // Next pin level on a compare match for one 4-bit action field.
  function automatic logic pin_next(input logic [3:0] field, input logic cur);
    logic res;
    if (field[3]) res = cur;
    else begin
      case (field[1:0])
        2'd1: res = 1'b0;
        2'd2: res = 1'b1;
        2'd3: res = ~cur;
        default: res = cur;
      endcase
    end
    return res;
  endfunction

  function automatic logic field_loads(input logic [3:0] field);
    return !field[3] && (field[1:0] != 2'd0);
  endfunction
endpackage

// File: rtl/mt_prescaler.sv
`timescale 1ns/1ps
module mt_prescaler
  import mt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic [2:0] psc,
  input  logic [1:0] edg,
  output logic       tick
);
  logic [PRE_W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  phase <= '0;
    else if (en) phase <= phase + PRE_W'(1);
    else         phase <= '0;
  end

  assign tick = en && presc_tick(psc, edg, phase);
endmodule

// File: rtl/mt_pin.sv
`timescale 1ns/1ps
module mt_pin
  import mt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [3:0] ld_field,
  input  logic [3:0] field,
  input  logic       match,
  output logic       pin
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else if (load && field_loads(ld_field)) pin <= ld_field[2];
    else if (match) pin <= pin_next(field, pin);
  end
endmodule

// File: rtl/mt_channel.sv
`timescale 1ns/1ps
module mt_channel
  import mt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             wr,
  input  logic             rd,
  input  logic [OFF_W-1:0] off,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic             pin_hi,
  output logic             pin_lo,
  output logic             irq,
  output logic             tick_o,
  output logic             match_o,
  output logic             flag_o,
  output logic             cclr_a_o,
  output logic             cnt_wr_o,
  output logic             io_wr_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [7:0]       ctrl;
  logic [3:0]       mode;
  logic [7:0]       ioc;
  logic             ien;
  logic             flag, armed;
  logic [CNT_W-1:0] cnt, cmp;
  logic             en, tick, match, cclr_a;
  logic             cnt_wr, io_wr, stat_wr, stat_rd, flag_clr;
  logic [1:0]       pins;

  assign cclr_a   = ctrl[7:5] == CLR_CMPA;
  assign en       = run && (mode == 4'd0);
  assign cnt_wr   = wr && ((off == OFF_CNTH) || (off == OFF_CNTL));
  assign io_wr    = wr && (off == OFF_IOC);
  assign stat_wr  = wr && (off == OFF_STAT);
  assign stat_rd  = rd && (off == OFF_STAT);
  assign flag_clr = stat_wr && !wdata[0] && armed;

  mt_prescaler u_psc (
    .clk  (clk),
    .rst_n(rst_n),
    .en   (en),
    .psc  (ctrl[2:0]),
    .edg  (ctrl[4:3]),
    .tick (tick)
  );

  assign match = tick && (cnt == cmp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl <= '0;
      mode <= '0;
      ioc  <= '0;
      ien  <= 1'b0;
      cmp  <= '0;
    end else if (wr) begin
      case (off)
        OFF_CTRL: ctrl <= wdata;
        OFF_MODE: mode <= wdata[3:0];
        OFF_IOC:  ioc  <= wdata;
        OFF_IEN:  ien  <= wdata[0];
        OFF_CMPH: cmp[15:8] <= wdata;
        OFF_CMPL: cmp[7:0]  <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (cnt_wr) begin
      if (off == OFF_CNTH) cnt[15:8] <= wdata;
      else                 cnt[7:0]  <= wdata;
    end else if (tick) begin
      if (match && cclr_a) cnt <= '0;
      else                 cnt <= cnt + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag  <= 1'b0;
      armed <= 1'b0;
    end else begin
      if (match)         flag <= 1'b1;
      else if (flag_clr) flag <= 1'b0;
      if (stat_rd)       armed <= flag;
      else if (stat_wr)  armed <= 1'b0;
    end
  end

  for (genvar p = 0; p < 2; p++) begin : g_pin
    mt_pin u_pin (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (io_wr),
      .ld_field(wdata[4*p+3:4*p]),
      .field   (ioc[4*p+3:4*p]),
      .match   (match),
      .pin     (pins[p])
    );
  end

  assign pin_lo = pins[0];
  assign pin_hi = pins[1];
  assign irq    = flag && ien;

  always_comb begin
    case (off)
      OFF_CTRL: rdata = ctrl;
      OFF_MODE: rdata = {4'd0, mode};
      OFF_IOC:  rdata = ioc;
      OFF_IEN:  rdata = {7'd0, ien};
      OFF_STAT: rdata = {7'd0, flag};
      OFF_CNTH: rdata = cnt[15:8];
      OFF_CNTL: rdata = cnt[7:0];
      OFF_CMPH: rdata = cmp[15:8];
      OFF_CMPL: rdata = cmp[7:0];
      default:  rdata = 8'd0;
    endcase
  end

  assign tick_o   = tick;
  assign match_o  = match;
  assign flag_o   = flag;
  assign cclr_a_o = cclr_a;
  assign cnt_wr_o = cnt_wr;
  assign io_wr_o  = io_wr;
  assign cnt_o    = cnt;
endmodule

// File: rtl/match_timer.sv
`timescale 1ns/1ps
module match_timer
  import mt_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic [NUM_CH-1:0] pin_hi,
  output logic [NUM_CH-1:0] pin_lo,
  output logic [NUM_CH-1:0] irq
);
  localparam int SEL_W = ADDR_W - OFF_W;
  localparam logic [ADDR_W-1:0] START_ADDR = ADDR_W'(NUM_CH << OFF_W);

  logic [NUM_CH-1:0]       start_q;
  logic [NUM_CH-1:0]       ch_sel;
  logic [7:0]              ch_rdata [NUM_CH];
  logic                    start_hit;

  // Internal events brought out for the checker.
  logic [NUM_CH-1:0]       ch_tick, ch_match, ch_flag, ch_cclr_a, ch_cnt_wr, ch_io_wr;
  logic [NUM_CH*CNT_W-1:0] ch_cnt;

  assign start_hit = bus_addr == START_ADDR;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) start_q <= '0;
    else if (bus_wr && start_hit) start_q <= bus_wdata[NUM_CH-1:0];
  end

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    assign ch_sel[g] = bus_addr[ADDR_W-1:OFF_W] == SEL_W'(g);

    mt_channel u_ch (
      .clk     (clk),
      .rst_n   (rst_n),
      .run     (start_q[g]),
      .wr      (bus_wr && ch_sel[g]),
      .rd      (bus_rd && ch_sel[g]),
      .off     (bus_addr[OFF_W-1:0]),
      .wdata   (bus_wdata),
      .rdata   (ch_rdata[g]),
      .pin_hi  (pin_hi[g]),
      .pin_lo  (pin_lo[g]),
      .irq     (irq[g]),
      .tick_o  (ch_tick[g]),
      .match_o (ch_match[g]),
      .flag_o  (ch_flag[g]),
      .cclr_a_o(ch_cclr_a[g]),
      .cnt_wr_o(ch_cnt_wr[g]),
      .io_wr_o (ch_io_wr[g]),
      .cnt_o   (ch_cnt[g*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    bus_rdata = 8'd0;
    if (start_hit) bus_rdata = 8'(start_q);
    for (int i = 0; i < NUM_CH; i++) begin
      if (ch_sel[i]) bus_rdata = ch_rdata[i];
    end
  end
endmodule

// File: rtl/mt_checker.sv
`timescale 1ns/1ps
module mt_checker #(
  parameter int NUM_CH = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NUM_CH-1:0]    run,
  input logic [NUM_CH-1:0]    tick,
  input logic [NUM_CH-1:0]    match,
  input logic [NUM_CH-1:0]    flag,
  input logic [NUM_CH-1:0]    cclr_a,
  input logic [NUM_CH-1:0]    cnt_wr,
  input logic [NUM_CH-1:0]    io_wr,
  input logic [NUM_CH*16-1:0] cnt,
  input logic [NUM_CH-1:0]    pin_hi,
  input logic [NUM_CH-1:0]    pin_lo,
  input logic [NUM_CH-1:0]    irq
);
  for (genvar g = 0; g < NUM_CH; g++) begin : g_chk
    a_r3_halt_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
      !run[g] |-> !tick[g]);
    a_r6_step: assert property (@(posedge clk) disable iff (!rst_n)
      (tick[g] && !match[g] && !cnt_wr[g]) |=> cnt[g*16 +: 16] == $past(cnt[g*16 +: 16]) + 16'd1);
    a_r7_clear_on_match: assert property (@(posedge clk) disable iff (!rst_n)
      (match[g] && cclr_a[g] && !cnt_wr[g]) |=> cnt[g*16 +: 16] == 16'd0);
    a_r11_match_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
      match[g] |=> flag[g]);
    a_r10_flag_rises_on_match_only: assert property (@(posedge clk) disable iff (!rst_n)
      (!flag[g] && !match[g]) |=> !flag[g]);
    a_r12_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq[g] |-> flag[g]);
    a_r9_pin_hi_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!match[g] && !io_wr[g]) |=> $stable(pin_hi[g]));
    a_r9_pin_lo_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!match[g] && !io_wr[g]) |=> $stable(pin_lo[g]));
  end
endmodule

bind match_timer mt_checker #(.NUM_CH(NUM_CH)) u_mt_checker (
  .clk   (clk),
  .rst_n (rst_n),
  .run   (start_q),
  .tick  (ch_tick),
  .match (ch_match),
  .flag  (ch_flag),
  .cclr_a(ch_cclr_a),
  .cnt_wr(ch_cnt_wr),
  .io_wr (ch_io_wr),
  .cnt   (ch_cnt),
  .pin_hi(pin_hi),
  .pin_lo(pin_lo),
  .irq   (irq)
);

// File: tb/match_timer_test.sv
`timescale 1ns/1ps
module match_timer_test;
  localparam int NUM_CH = 3;
  localparam int ADDR_W = 6;
  localparam logic [5:0] A_RUN = 6'h30;
  localparam int NV = 10;
  // {psc[3], edge[2], clear[3], cmp[16], start count[16], ticks-window[16]}
  localparam logic [55:0] VECS [NV] = '{
    {3'd0, 2'd0, 3'd0, 16'd100,  16'h0000, 16'd10},
    {3'd0, 2'd0, 3'd1, 16'd4,    16'h0000, 16'd12},
    {3'd1, 2'd0, 3'd0, 16'd1000, 16'h0000, 16'd20},
    {3'd1, 2'd1, 3'd0, 16'd1000, 16'h0000, 16'd21},
    {3'd1, 2'd2, 3'd0, 16'd1000, 16'h0000, 16'd9},
    {3'd2, 2'd0, 3'd1, 16'd2,    16'h0000, 16'd100},
    {3'd3, 2'd3, 3'd0, 16'd1000, 16'h0000, 16'd200},
    {3'd0, 2'd0, 3'd0, 16'd5,    16'hFFFE, 16'd3},
    {3'd0, 2'd0, 3'd0, 16'd3,    16'h0000, 16'd6},
    {3'd5, 2'd0, 3'd0, 16'd1000, 16'h0007, 16'd10}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  wire  [7:0] bus_rdata;
  wire  [NUM_CH-1:0] pin_hi, pin_lo, irq;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  match_timer #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_hi(pin_hi), .pin_lo(pin_lo), .irq(irq)
  );

  function automatic logic [5:0] ra(input int ch, input int off);
    return 6'(ch * 16 + off);
  endfunction

  task automatic wr(input logic [5:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    #1;
    d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rd16(input int ch, input int off, output int v);
    logic [7:0] h, l;
    rd(ra(ch, off), h);
    rd(ra(ch, off + 1), l);
    v = {h, l};
  endtask

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic w16(input int ch, input int off, input int v);
    wr(ra(ch, off), v[15:8]);
    wr(ra(ch, off + 1), v[7:0]);
  endtask

  task automatic clear_flag(input int ch);
    logic [7:0] d;
    rd(ra(ch, 5), d);
    wr(ra(ch, 5), 8'h00);
  endtask

  // Run channel 0 for exactly k counting cycles (k >= 1).
  task automatic run0(input int k);
    wr(A_RUN, 8'h01);
    repeat (k - 1) @(negedge clk);
    wr(A_RUN, 8'h00);
  endtask

  // Independent model of a run window of k cycles.
  task automatic model(input int psc, input int edg, input int clr, input int cmp,
                       input int st, input int k, output int cnt, output int flg);
    int n;
    bit t, hr, hf;
    cnt = st; flg = 0;
    n = 1 << (2 * psc);
    for (int j = 0; j < k; j++) begin
      hr = (j % n) == (n / 2 - 1);
      hf = (j % n) == (n - 1);
      if (psc == 0)      t = 1'b1;
      else if (psc > 3)  t = 1'b0;
      else if (edg == 0) t = hr;
      else if (edg == 1) t = hf;
      else               t = hr | hf;
      if (t) begin
        if (cnt == cmp) begin
          flg = 1;
          cnt = (clr == 1) ? 0 : ((cnt + 1) & 16'hFFFF);
        end else cnt = (cnt + 1) & 16'hFFFF;
      end
    end
  endtask

  function automatic string vreq(input int i);
    case (i)
      0: return "R6 div1";
      1: return "R7 period";
      2: return "R5 rising";
      3: return "R5 falling";
      4: return "R5 both";
      5: return "R4 div16";
      6: return "R4 div64";
      7: return "R6 wrap";
      8: return "R7 noclear";
      default: return "R4 reserved";
    endcase
  endfunction

  task automatic run_vec(input int i);
    logic [55:0] v;
    int psc, edg, clr, cmp, st, k, ec, ef, ac;
    logic [7:0] s;
    v = VECS[i];
    psc = int'(v[55:53]); edg = int'(v[52:51]); clr = int'(v[50:48]);
    cmp = int'(v[47:32]); st = int'(v[31:16]); k = int'(v[15:0]);
    wr(A_RUN, 8'h00);
    wr(ra(0, 0), {v[50:48], v[52:51], v[55:53]});
    w16(0, 8, cmp);
    w16(0, 6, st);
    clear_flag(0);
    run0(k);
    rd16(0, 6, ac);
    rd(ra(0, 5), s);
    model(psc, edg, clr, cmp, st, k, ec, ef);
    chk(vreq(i), "counter", ac, ec);
    chk(vreq(i), "flag", int'(s[0]), ef);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    int v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int ch = 0; ch < NUM_CH; ch++) begin
      for (int o = 0; o < 10; o++) begin
        rd(ra(ch, o), d);
        chk("R1", $sformatf("ch%0d off%0d", ch, o), int'(d), 0);
      end
    end
    rd(A_RUN, d);
    chk("R1", "run register", int'(d), 0);
    chk("R1", "pins", int'({pin_hi, pin_lo}), 0);
    chk("R1", "irq", int'(irq), 0);

    // R2 address map
    wr(ra(0, 3), 8'hFF);
    rd(ra(0, 3), d);
    chk("R2", "unassigned offset 3", int'(d), 0);
    rd(6'h31, d);
    chk("R2", "address past run register", int'(d), 0);
    w16(2, 8, 16'h1234);
    rd16(2, 8, v);
    chk("R2", "ch2 compare", v, 16'h1234);
    rd16(0, 8, v);
    chk("R2", "ch0 compare untouched", v, 0);
    wr(ra(2, 2), 8'h5A);
    rd(ra(2, 2), d);
    chk("R2", "ch2 pin-action byte", int'(d), 8'h5A);

    // R4 R5 R6 R7 vector table
    for (int i = 0; i < NV; i++) run_vec(i);

    // R3 independent run bits
    wr(ra(0, 0), 8'h00);
    w16(0, 6, 16'h0055);
    wr(ra(1, 0), 8'h00);
    w16(1, 6, 0);
    wr(A_RUN, 8'h02);
    rd(A_RUN, d);
    repeat (8) @(negedge clk);
    wr(A_RUN, 8'h00);
    chk("R3", "run register readback", int'(d), 2);
    rd16(1, 6, v);
    chk("R3", "ch1 count", v, 10);
    rd16(0, 6, v);
    chk("R3", "halted ch0 count", v, 16'h0055);

    // R8 non-normal mode holds the counter
    wr(ra(0, 1), 8'h01);
    run0(6);
    rd16(0, 6, v);
    chk("R8", "count in mode 1", v, 16'h0055);
    wr(ra(0, 1), 8'h00);

    // R13 counter write while running
    w16(0, 8, 16'h1000);
    w16(0, 6, 0);
    wr(A_RUN, 8'h01);
    repeat (3) @(negedge clk);
    wr(ra(0, 7), 8'hF0);
    wr(A_RUN, 8'h00);
    rd16(0, 6, v);
    chk("R13", "count after running write", v, 16'h00F1);

    // R10 R12 flag clear protocol and interrupt
    w16(0, 8, 5);
    w16(0, 6, 5);
    wr(ra(0, 4), 8'h00);
    clear_flag(0);
    run0(1);
    chk("R12", "irq disabled", int'(irq[0]), 0);
    wr(ra(0, 5), 8'h00);
    rd(ra(0, 5), d);
    chk("R10", "flag after unarmed clear", int'(d[0]), 1);
    wr(ra(0, 5), 8'h01);
    rd(ra(0, 5), d);
    chk("R10", "flag after writing 1", int'(d[0]), 1);
    wr(ra(0, 4), 8'h01);
    chk("R12", "irq enabled", int'(irq[0]), 1);
    wr(ra(0, 5), 8'h00);
    rd(ra(0, 5), d);
    chk("R10", "flag after armed clear", int'(d[0]), 0);
    chk("R12", "irq after clear", int'(irq[0]), 0);

    // R11 match wins over clear
    wr(ra(0, 0), 8'h20);
    w16(0, 8, 0);
    w16(0, 6, 0);
    wr(A_RUN, 8'h01);
    @(negedge clk);
    rd(ra(0, 5), d);
    wr(ra(0, 5), 8'h00);
    wr(A_RUN, 8'h00);
    rd(ra(0, 5), d);
    chk("R11", "flag with match during clear", int'(d[0]), 1);

    // R9 pin actions (period 4 ticks)
    w16(0, 8, 3);
    w16(0, 6, 0);
    wr(ra(0, 2), 8'h32);
    chk("R9", "init hi", int'(pin_hi[0]), 0);
    chk("R9", "init lo", int'(pin_lo[0]), 0);
    run0(4);
    chk("R9", "toggle hi 1", int'(pin_hi[0]), 1);
    chk("R9", "set lo 1", int'(pin_lo[0]), 1);
    run0(4);
    chk("R9", "toggle hi 2", int'(pin_hi[0]), 0);
    chk("R9", "set lo 2", int'(pin_lo[0]), 1);
    wr(ra(0, 2), 8'h51);
    chk("R9", "init-high hi", int'(pin_hi[0]), 1);
    chk("R9", "init-low lo", int'(pin_lo[0]), 0);
    run0(4);
    chk("R9", "clear hi", int'(pin_hi[0]), 0);
    chk("R9", "clear lo", int'(pin_lo[0]), 0);
    wr(ra(0, 2), 8'h63);
    run0(4);
    chk("R9", "set hi", int'(pin_hi[0]), 1);
    chk("R9", "toggle lo", int'(pin_lo[0]), 1);
    wr(ra(0, 2), 8'h03);
    chk("R9", "retain hi on write", int'(pin_hi[0]), 1);
    chk("R9", "reload lo", int'(pin_lo[0]), 0);
    run0(4);
    chk("R9", "retain hi on match", int'(pin_hi[0]), 1);
    chk("R9", "toggle lo again", int'(pin_lo[0]), 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule